// File: doc/BRIEF.md
# Prescaled Master Period Counter

This block is the master timebase of a pulse-generation subsystem. A 16-bit counter starts at zero and counts up to a programmable period value. Each step is taken once every 2^N input clocks, where N is a 3-bit prescaler code. In continuous mode the counter wraps to zero after the period value and keeps running. In single-shot mode it stops at the period value and holds there until it is restarted. A one-cycle period-event pulse marks each time the counter arrives at the period value.

A restart returns the counter to zero. A restart comes from a software request or from a synchronization input, and a synchronization input acts only when its reset enable is set. A 2-bit source code picks the synchronization input: either an on-chip pulse or the rising edge of an external signal. In single-shot mode a re-trigger option decides whether a restart can cut into a run that is still in progress. The prescaler code and the synchronization source are captured while the enable is low and are frozen while it is high. Driving the enable low clears the counter and the prescaler divider.

The control is a three-state machine:
- **IDLE**: disabled, counter at zero.
- **RUN**: counting.
- **HALT**: single-shot run finished, counter holding the period value.

Its transitions are:
- **ENABLE** (IDLE→RUN): the enable is high.
- **DISABLE** (any state→IDLE): the enable is low.
- **FINISH** (RUN→HALT): a single-shot run reaches the period value.
- **RESTART** (HALT→RUN, or RUN→RUN): an accepted restart.

Top module: `mstr_timebase`

## Requirements
- R1: While `en` is low (and after reset) the machine is in IDLE. One clock edge after `en` is sampled low, `count` is 0, `running` is 0 and `period_evt` is 0, and the prescaler divider is cleared.
- R2: In continuous mode (`cont_mode`=1) the counter steps 0,1,…,P and then back to 0, repeating without stopping, where P is `period` and P ≥ 1.
- R3: In single-shot mode (`cont_mode`=0) the counter stops at P. From then on `running` is 0 and `count` holds P.
- R4: `period_evt` is high for exactly one cycle: the first cycle in which `count` equals P after an increment.
- R5: The counter advances once every 2^`psc_sel` clocks, counted from the clock after the machine enters RUN. The `psc_sel` value in force is the one present while `en` was low. Changes made while `en` is high have no effect.
- R6: In single-shot mode with `retrig`=0, a restart request is ignored while the counter is running. Once the counter has stopped, a restart request returns it to 0 and it runs again.
- R7: With `retrig`=1, or in continuous mode, a restart request clears `count` to 0 on the next edge, even while the counter is running.
- R8: `sync_src` selects the synchronization event. Code 00 means none and 01 is reserved and also means none. Code 10 means `sync_int` high at the edge. Code 11 means a rising edge on `sync_ext`, so holding `sync_ext` high causes a single restart.
- R9: When `sync_rst_en` is 0, synchronization events do not change the counter.
- R10: `sync_src` is captured only while `en` is low. Changes made while `en` is high have no effect.
- R11: When an accepted restart falls on the same edge as the step that would reach P, the restart wins. `count` becomes 0 and `period_evt` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer enable |
| period | input | 16 | Period value P |
| cont_mode | input | 1 | 1 = continuous, 0 = single-shot |
| retrig | input | 1 | Allow a restart while a single-shot run is in progress |
| psc_sel | input | 3 | Prescaler code N, ratio 2^N |
| sync_rst_en | input | 1 | Let synchronization events restart the counter |
| sync_src | input | 2 | Synchronization source code |
| sync_int | input | 1 | On-chip synchronization pulse |
| sync_ext | input | 1 | External synchronization signal (rising edge used) |
| sw_rst | input | 1 | Software restart request |
| count | output | 16 | Counter value |
| running | output | 1 | Machine is in RUN |
| period_evt | output | 1 | One-cycle pulse on arrival at P |

## Verification
A restart (the RESTART transition) and the step that reaches the period value (the FINISH transition or the wrap) can land on the same clock edge. The bench provokes this in continuous mode with P=3. It holds `sync_int` high across exactly the edge that would move the counter from 2 to 3. It then expects `count` to read 0 and `period_evt` to stay low in the cycle after. Both outputs are set by the same edge, so they are sampled together at the next falling edge.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_RUN  = 2'd1,
        TB_HALT = 2'd2
    } tb_state_e;

    localparam logic [1:0] SRC_NONE = 2'b00;
    localparam logic [1:0] SRC_RSVD = 2'b01;
    localparam logic [1:0] SRC_INT  = 2'b10;
    localparam logic [1:0] SRC_EXT  = 2'b11;
endpackage

// File: rtl/mtb_cfg_lock.sv
module mtb_cfg_lock #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Setting follows its input while disabled, frozen while enabled.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (!en)
            q <= d;
    end
endmodule

// File: rtl/mtb_prescaler.sv
module mtb_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = ~({DIV_W{1'b1}} << psc);
    assign tick = active && !clr && (div_q == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (clr)
            div_q <= '0;
        else if (active)
            div_q <= tick ? '0 : div_q + 1'b1;
    end
endmodule

// File: rtl/mtb_sync_sel.sv
module mtb_sync_sel
    import mtb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       sync_int,
    input  logic       sync_ext,
    output logic       sync_evt
);
    logic ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ext_q <= 1'b0;
        else
            ext_q <= sync_ext;
    end

    always_comb begin
        unique case (src)
            SRC_INT: sync_evt = sync_int;
            SRC_EXT: sync_evt = sync_ext && !ext_q;
            default: sync_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/mstr_timebase.sv
module mstr_timebase
    import mtb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic             cont_mode,
    input  logic             retrig,
    input  logic [PSC_W-1:0] psc_sel,
    input  logic             sync_rst_en,
    input  logic [1:0]       sync_src,
    input  logic             sync_int,
    input  logic             sync_ext,
    input  logic             sw_rst,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             period_evt
);
    localparam int SRC_W = 2;

    tb_state_e        state_q, state_d;
    logic [PSC_W-1:0] psc_lk;
    logic [SRC_W-1:0] src_lk;
    logic             sync_evt;
    logic             restart_req;
    logic             do_restart;
    logic             tick;
    logic             div_clr;
    logic             at_or_past;
    logic [CNT_W:0]   inc;
    logic             inc_hits;

    mtb_cfg_lock #(.W(PSC_W)) u_psc_lock (
        .clk(clk), .rst_n(rst_n), .en(en), .d(psc_sel), .q(psc_lk)
    );

    mtb_cfg_lock #(.W(SRC_W)) u_src_lock (
        .clk(clk), .rst_n(rst_n), .en(en), .d(sync_src), .q(src_lk)
    );

    mtb_sync_sel u_sync (
        .clk(clk), .rst_n(rst_n), .src(src_lk),
        .sync_int(sync_int), .sync_ext(sync_ext), .sync_evt(sync_evt)
    );

    assign restart_req = sw_rst || (sync_rst_en && sync_evt);

    // Restart acceptance depends on the run state and the mode.
    always_comb begin
        do_restart = 1'b0;
        unique case (state_q)
            TB_HALT: do_restart = restart_req;
            TB_RUN:  do_restart = restart_req && (cont_mode || retrig);
            default: do_restart = 1'b0;
        endcase
    end

    assign div_clr = !en || (state_q != TB_RUN) || do_restart;

    mtb_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr(div_clr),
        .active(state_q == TB_RUN), .psc(psc_lk), .tick(tick)
    );

    assign inc        = {1'b0, count} + 1'b1;
    assign at_or_past = (count >= period);
    assign inc_hits   = (inc == {1'b0, period});

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = TB_IDLE;
        end else begin
            unique case (state_q)
                TB_IDLE: state_d = TB_RUN;
                TB_RUN: begin
                    if (do_restart)
                        state_d = TB_RUN;
                    else if (tick && !cont_mode && (at_or_past || inc_hits))
                        state_d = TB_HALT;
                end
                TB_HALT: if (do_restart) state_d = TB_RUN;
                default: state_d = TB_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TB_IDLE;
        else
            state_q <= state_d;
    end

    // Output register: counter and period event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            period_evt <= 1'b0;
        end else if (!en) begin
            count      <= '0;
            period_evt <= 1'b0;
        end else begin
            period_evt <= 1'b0;
            unique case (state_q)
                TB_IDLE: count <= '0;
                TB_RUN: begin
                    if (do_restart) begin
                        count <= '0;
                    end else if (tick) begin
                        if (at_or_past) begin
                            if (cont_mode)
                                count <= '0;
                        end else begin
                            count      <= inc[CNT_W-1:0];
                            period_evt <= inc_hits;
                        end
                    end
                end
                TB_HALT: if (do_restart) count <= '0;
                default: count <= '0;
            endcase
        end
    end

    assign running = (state_q == TB_RUN);
endmodule

// File: rtl/mtb_checker.sv
module mtb_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] period,
    input logic             sync_int,
    input logic             sync_ext,
    input logic             sw_rst,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             period_evt
);
    p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == '0) && !running && !period_evt);

    p_evt_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |-> (count == $past(period)));

    p_evt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |=> !period_evt);

    p_stopped_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !running && !sw_rst && !sync_int && !sync_ext) |=> $stable(count));

    p_step_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && running) |=> ((count == $past(count)) || (count == '0) ||
                             (count == $past(count) + 1'b1)));
endmodule

bind mstr_timebase mtb_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period),
    .sync_int(sync_int), .sync_ext(sync_ext), .sw_rst(sw_rst),
    .count(count), .running(running), .period_evt(period_evt)
);

// File: tb/mstr_timebase_tb.sv
module mstr_timebase_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] period = 16'd5;
    logic        cont_mode = 1'b0;
    logic        retrig = 1'b0;
    logic [2:0]  psc_sel = 3'd0;
    logic        sync_rst_en = 1'b0;
    logic [1:0]  sync_src = 2'b00;
    logic        sync_int = 1'b0;
    logic        sync_ext = 1'b0;
    logic        sw_rst = 1'b0;
    logic [15:0] count;
    logic        running;
    logic        period_evt;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mstr_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .period(period),
        .cont_mode(cont_mode), .retrig(retrig), .psc_sel(psc_sel),
        .sync_rst_en(sync_rst_en), .sync_src(sync_src),
        .sync_int(sync_int), .sync_ext(sync_ext), .sw_rst(sw_rst),
        .count(count), .running(running), .period_evt(period_evt)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Disable, apply settings, enable; returns after the edge that enters RUN.
    task automatic start(input int psc, input int per, input bit cm, input bit rt,
                         input bit sre, input logic [1:0] src);
        @(negedge clk);
        en = 1'b0;
        psc_sel = psc[2:0];
        period = per[15:0];
        cont_mode = cm;
        retrig = rt;
        sync_rst_en = sre;
        sync_src = src;
        step(2);
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_sw;
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
    endtask

    task automatic pulse_int;
        sync_int = 1'b1;
        @(negedge clk);
        sync_int = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        step(3);
        chk("R1", "reset count", int'(count), 0);
        chk("R1", "reset running", int'(running), 0);
        chk("R1", "reset evt", int'(period_evt), 0);
        rst_n = 1'b1;
        step(2);

        // Sweep: prescaler codes, periods, both modes (R2, R3, R4, R5)
        for (int psc = 0; psc < 4; psc++) begin
            for (int pi = 0; pi < 2; pi++) begin
                for (int cm = 0; cm < 2; cm++) begin
                    int p;
                    int r;
                    int len;
                    p = (pi == 0) ? 3 : 5;
                    r = 1 << psc;
                    len = (p + 1) * r * 2 + 4;
                    start(psc, p, cm[0], 1'b0, 1'b0, 2'b00);
                    psc_sel = 3'(psc ^ 3); // R5: change while enabled, must be ignored
                    for (int j = 1; j <= len; j++) begin
                        int t;
                        int ec;
                        int er;
                        int ee;
                        if (j > 1) @(negedge clk);
                        t = (j - 1) / r;
                        if (cm == 1) begin
                            ec = t % (p + 1);
                            er = 1;
                            ee = (j >= 2 && (j - 1) % r == 0 && ec == p) ? 1 : 0;
                            chk("R2", "cont count", int'(count), ec);
                        end else begin
                            ec = (t < p) ? t : p;
                            er = (t < p) ? 1 : 0;
                            ee = (j >= 2 && (j - 1) % r == 0 && t == p) ? 1 : 0;
                            chk("R3", "single count", int'(count), ec);
                        end
                        chk("R5", "running", int'(running), er);
                        chk("R4", "period_evt", int'(period_evt), ee);
                    end
                end
            end
        end

        // R1: disable clears
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R1", "count after disable", int'(count), 0);
        chk("R1", "running after disable", int'(running), 0);

        // R6: no re-trigger in single-shot
        start(0, 4, 1'b0, 1'b0, 1'b0, 2'b00);
        step(2);
        pulse_sw;
        chk("R6", "restart ignored while running", int'(count), 3);
        step(1);
        chk("R6", "stopped at period", int'(count), 4);
        chk("R6", "stopped running flag", int'(running), 0);
        step(2);
        chk("R6", "held while stopped", int'(count), 4);
        pulse_sw;
        chk("R6", "restart after stop", int'(count), 0);
        chk("R6", "running after restart", int'(running), 1);
        step(1);
        chk("R6", "counts after restart", int'(count), 1);

        // R7: re-trigger while running, and continuous restart
        start(0, 10, 1'b0, 1'b1, 1'b0, 2'b00);
        step(3);
        pulse_sw;
        chk("R7", "retrig restart", int'(count), 0);
        step(1);
        chk("R7", "retrig counts again", int'(count), 1);
        start(0, 10, 1'b1, 1'b0, 1'b0, 2'b00);
        step(4);
        pulse_sw;
        chk("R7", "continuous restart", int'(count), 0);

        // R8: internal source
        start(0, 20, 1'b1, 1'b0, 1'b1, 2'b10);
        step(3);
        pulse_int;
        chk("R8", "internal sync restart", int'(count), 0);

        // R8: external rising edge only once while held high
        start(0, 20, 1'b1, 1'b0, 1'b1, 2'b11);
        step(3);
        sync_ext = 1'b1;
        @(negedge clk);
        chk("R8", "external edge restart", int'(count), 0);
        step(2);
        chk("R8", "external level held no repeat", int'(count), 2);
        sync_ext = 1'b0;
        step(1);
        chk("R8", "external low", int'(count), 3);

        // R8: reserved code behaves as none
        start(0, 20, 1'b1, 1'b0, 1'b1, 2'b01);
        step(3);
        pulse_int;
        chk("R8", "reserved code no sync", int'(count), 4);

        // R9: sync reset disabled
        start(0, 20, 1'b1, 1'b0, 1'b0, 2'b10);
        step(3);
        pulse_int;
        chk("R9", "sync ignored when disabled", int'(count), 4);

        // R10: source locked while enabled
        start(0, 20, 1'b1, 1'b0, 1'b1, 2'b00);
        sync_src = 2'b10;
        step(2);
        pulse_int;
        chk("R10", "source change while enabled ignored", int'(count), 3);

        // R11: restart on the same edge as reaching the period
        start(0, 3, 1'b1, 1'b0, 1'b1, 2'b10);
        step(2);
        chk("R11", "count before collision", int'(count), 2);
        pulse_int;
        chk("R11", "restart wins count", int'(count), 0);
        chk("R11", "restart wins no event", int'(period_evt), 0);

        @(negedge clk);
        en = 1'b0;
        step(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule